// File: doc/BRIEF.md
# Standby and Current-Detect Controller

This block owns the power state of a multichannel ADC. The host can park the converter in standby or wake it with 16-bit command words. Standby turns off the channels and the reference. Register contents are kept. On wakeup the channels and the reference come back at once. The modulator-ready flag rises only after a fixed settling interval.

From standby, a brief low pulse on the active-low sync/reset input starts a tamper-detect mode. In that mode the block receives samples from the conversion datapath and compares the magnitude of each sample with a programmable threshold. It counts how many samples exceed the threshold. If that count reaches a programmable limit before a programmable sample budget runs out, the block pulses data-ready low for one cycle and goes back to standby. If the budget runs out first, it goes back to standby with no pulse.

The detect samples are used only inside the block and never reach an output. A low level on sync/reset that lasts for the reset length resets the block to its power-on state, whatever state it is in.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After rst_ni is released the block is in the run state. chan_en_o, ref_en_o, mod_ready_o and drdy_no are 1, and det_mode_o is 0.
- R2: A command word 16'h0022 with cmd_valid_i, in run or settling, enters standby on that edge. From the next cycle chan_en_o, ref_en_o, mod_ready_o and det_mode_o are 0.
- R3: A command word 16'h0033 in standby sets chan_en_o and ref_en_o to 1 from the next cycle. mod_ready_o stays 0 for SETTLE_CYC (8) cycles and is 1 after that. Any other command word has no effect.
- R4: In standby, a low pulse on sync_ni of 1 to RST_LEN-1 (15) cycles enters detect mode (det_mode_o=1) on the edge where sync_ni returns high. The same pulse in run state has no effect.
- R5: If sync_ni is low for RST_LEN (16) consecutive cycles, the block returns to the R1 state on the 16th low edge, from any state. Releasing sync_ni afterwards does not start detect mode.
- R6: In detect mode, each sample with smp_valid_i is a two's-complement value. Its magnitude counts as an exceedance only if it is strictly greater than thr_i. Magnitude means the absolute value, except that the most negative code is taken as the largest positive code.
- R7: When the exceedance count reaches hit_limit_i, drdy_no goes low for exactly one cycle and the block enters standby. This applies even on the last sample of the budget.
- R8: When smp_budget_i samples have been taken without reaching hit_limit_i, the block enters standby and drdy_no stays 1.
- R9: Samples outside detect mode are ignored, and command words inside detect mode are ignored. Both counters restart from zero each time detect mode is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command word strobe |
| cmd_i | input | 16 | Host command word |
| sync_ni | input | 1 | Active-low sync/reset line, already synchronized |
| smp_valid_i | input | 1 | Detect-mode sample strobe |
| smp_i | input | DW (24) | Two's-complement detect sample |
| thr_i | input | DW (24) | Unsigned magnitude threshold |
| smp_budget_i | input | CW (8) | Samples per detect run, 1 or more |
| hit_limit_i | input | CW (8) | Exceedances needed to signal, 1 or more |
| chan_en_o | output | 1 | Channels enabled |
| ref_en_o | output | 1 | Reference enabled |
| mod_ready_o | output | 1 | Modulators settled and sampling |
| det_mode_o | output | 1 | Detect mode active |
| drdy_no | output | 1 | Active-low data-ready pulse |

## Verification
The corner cases that are hardest to reach from the ports all sit inside detect mode. The block gets there only from standby and only through a timed low pulse.

The bench therefore reaches every magnitude vector the same way: a standby command, a short pulse, then a single sample with a budget and limit of one. This covers the strict-greater boundary and the saturated most-negative code.

The stale-count case works the same way. A detect run is left with one exceedance already counted, and a new run then has to need the full limit again.

The pulse-length boundary is checked at both ends: RST_LEN-1 low cycles must enter detect mode, and RST_LEN low cycles must reset the block.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  typedef enum logic [1:0] {ST_RUN, ST_STBY, ST_SETTLE, ST_DET} pwr_state_e;
  localparam logic [15:0] CMD_STBY = 16'h0022;
  localparam logic [15:0] CMD_WAKE = 16'h0033;
endpackage

// File: rtl/sync_pulse_meas.sv
module sync_pulse_meas #(
  parameter int RST_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_ni,
  output logic short_o,
  output logic long_o
);
  localparam int LW = $clog2(RST_LEN + 1);
  localparam logic [LW-1:0] LIM = LW'(RST_LEN);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lo_cnt <= '0;
    else if (sync_ni)  lo_cnt <= '0;
    else if (lo_cnt != LIM) lo_cnt <= lo_cnt + 1'b1;
  end

  // release after a pulse shorter than the reset length
  assign short_o = sync_ni && (lo_cnt != '0) && (lo_cnt < LIM);
  // fires on the RST_LEN-th low edge only
  assign long_o  = !sync_ni && (lo_cnt == LIM - 1'b1);

  p_cnt_sat_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_cnt <= LIM);
  p_long_once_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    long_o |=> !long_o);
endmodule

// File: rtl/abs_thr_cmp.sv
module abs_thr_cmp #(
  parameter int DW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] thr_i,
  output logic          hit_o
);
  localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};

  logic [DW-1:0] mag;

  always_comb begin
    if (!smp_i[DW-1])        mag = smp_i;
    else if (smp_i == NEG_MIN) mag = POS_MAX;
    else                     mag = -smp_i;
  end

  assign hit_o = mag > thr_i;

  p_mag_pos_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mag[DW-1]);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int SETTLE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int TW = $clog2(SETTLE_CYC + 1);
  localparam logic [TW-1:0] LAST = TW'(SETTLE_CYC - 1);

  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt <= '0;
    else if (!run_i) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  assign done_o = run_i && (cnt == LAST);

  p_settle_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt <= LAST);
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_pkg::*;
#(
  parameter int DW         = 24,
  parameter int CW         = 8,
  parameter int RST_LEN    = 16,
  parameter int SETTLE_CYC = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  input  logic [15:0]   cmd_i,
  input  logic          sync_ni,
  input  logic          smp_valid_i,
  input  logic [DW-1:0] smp_i,
  input  logic [DW-1:0] thr_i,
  input  logic [CW-1:0] smp_budget_i,
  input  logic [CW-1:0] hit_limit_i,
  output logic          chan_en_o,
  output logic          ref_en_o,
  output logic          mod_ready_o,
  output logic          det_mode_o,
  output logic          drdy_no
);
  pwr_state_e    state;
  logic          short_p, long_p, settle_done, hit;
  logic [CW-1:0] smp_cnt, hit_cnt, smp_nxt, hit_nxt;
  logic          is_stby_cmd, is_wake_cmd;

  sync_pulse_meas #(.RST_LEN(RST_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_ni(sync_ni),
    .short_o(short_p), .long_o(long_p)
  );

  abs_thr_cmp #(.DW(DW)) u_cmp (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp_i), .thr_i(thr_i), .hit_o(hit)
  );

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(state == ST_SETTLE),
    .done_o(settle_done)
  );

  assign is_stby_cmd = cmd_valid_i && (cmd_i == CMD_STBY);
  assign is_wake_cmd = cmd_valid_i && (cmd_i == CMD_WAKE);
  assign smp_nxt     = smp_cnt + 1'b1;
  assign hit_nxt     = hit_cnt + CW'(hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state   <= ST_RUN;
      smp_cnt <= '0;
      hit_cnt <= '0;
      drdy_no <= 1'b1;
    end else if (long_p) begin
      state   <= ST_RUN;
      smp_cnt <= '0;
      hit_cnt <= '0;
      drdy_no <= 1'b1;
    end else begin
      drdy_no <= 1'b1;
      unique case (state)
        ST_RUN:    if (is_stby_cmd) state <= ST_STBY;
        ST_SETTLE: begin
          if (is_stby_cmd)      state <= ST_STBY;
          else if (settle_done) state <= ST_RUN;
        end
        ST_STBY: begin
          if (is_wake_cmd) state <= ST_SETTLE;
          else if (short_p) begin
            state   <= ST_DET;
            smp_cnt <= '0;
            hit_cnt <= '0;
          end
        end
        ST_DET: if (smp_valid_i) begin
          smp_cnt <= smp_nxt;
          hit_cnt <= hit_nxt;
          if (hit && hit_nxt == hit_limit_i) begin
            drdy_no <= 1'b0;
            state   <= ST_STBY;
          end else if (smp_nxt == smp_budget_i) begin
            state   <= ST_STBY;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign chan_en_o   = (state == ST_RUN) || (state == ST_SETTLE);
  assign ref_en_o    = chan_en_o;
  assign mod_ready_o = (state == ST_RUN);
  assign det_mode_o  = (state == ST_DET);

  p_drdy_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_no |=> drdy_no);
  p_drdy_stby_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drdy_no |-> state == ST_STBY);
  p_det_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DET && $past(state) != ST_DET) |-> $past(state) == ST_STBY);
  p_ready_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mod_ready_o) |-> ($past(state) == ST_SETTLE || $past(long_p)));
  p_hits_le_smps_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt <= smp_cnt);
endmodule

// File: tb/sim_pwr_state_ctrl.sv
module sim_pwr_state_ctrl;
  localparam int DW = 24;
  localparam int CW = 8;
  localparam int RST_LEN = 16;
  localparam int SETTLE_CYC = 8;
  localparam int NV = 8;

  // {sample, threshold, expect_hit}
  localparam logic [2*DW:0] VEC [NV] = '{
    {24'd100,     24'd99,      1'b1},
    {24'd100,     24'd100,     1'b0},
    {24'hFFFF9C,  24'd99,      1'b1},
    {24'hFFFF9C,  24'd100,     1'b0},
    {24'h800000,  24'h7FFFFE,  1'b1},
    {24'h800000,  24'h7FFFFF,  1'b0},
    {24'h7FFFFF,  24'h7FFFFE,  1'b1},
    {24'h000000,  24'h000000,  1'b0}
  };

  logic clk = 0, rst_ni = 0, cmd_valid = 0, sync_n = 1, smp_valid = 0;
  logic [15:0] cmd = '0;
  logic [DW-1:0] smp = '0, thr = '0;
  logic [CW-1:0] budget = 8'd1, limit = 8'd1;
  logic chan_en, ref_en, mod_ready, det_mode, drdy_n;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwr_state_ctrl #(.DW(DW), .CW(CW), .RST_LEN(RST_LEN), .SETTLE_CYC(SETTLE_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .sync_ni(sync_n), .smp_valid_i(smp_valid), .smp_i(smp), .thr_i(thr),
    .smp_budget_i(budget), .hit_limit_i(limit), .chan_en_o(chan_en),
    .ref_en_o(ref_en), .mod_ready_o(mod_ready), .det_mode_o(det_mode),
    .drdy_no(drdy_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {chan, ref, ready, det}
  function automatic int st4();
    return {28'd0, chan_en, ref_en, mod_ready, det_mode};
  endfunction

  task automatic send_cmd(input logic [15:0] c);
    @(negedge clk); cmd_valid = 1; cmd = c;
    @(negedge clk); cmd_valid = 0;
  endtask

  task automatic low_pulse(input int n);
    @(negedge clk); sync_n = 0;
    repeat (n) @(negedge clk);
    sync_n = 1;
    @(negedge clk);
  endtask

  task automatic feed(input logic [DW-1:0] s);
    @(negedge clk); smp_valid = 1; smp = s;
    @(negedge clk); smp_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk(st4() == 4'b1110 && drdy_n, "R1 reset state", st4(), 4'b1110);

    low_pulse(3);
    chk(st4() == 4'b1110, "R4 short pulse in run ignored", st4(), 4'b1110);
    send_cmd(16'h1234);
    chk(st4() == 4'b1110, "R3 unknown command ignored", st4(), 4'b1110);
    send_cmd(16'h0022);
    chk(st4() == 4'b0000, "R2 standby", st4(), 4'b0000);
    send_cmd(16'h0033);
    chk(st4() == 4'b1100, "R3 wake enables, not ready", st4(), 4'b1100);
    repeat (SETTLE_CYC - 1) @(negedge clk);
    chk(!mod_ready, "R3 still settling", mod_ready, 0);
    @(negedge clk);
    chk(mod_ready, "R3 ready after settle", mod_ready, 1);
    send_cmd(16'h0022);

    budget = 8'd1; limit = 8'd1;
    for (int i = 0; i < NV; i++) begin
      thr = VEC[i][DW:1];
      low_pulse(3);
      chk(det_mode, "R4 detect entry", det_mode, 1);
      feed(VEC[i][2*DW:DW+1]);
      chk(drdy_n == !VEC[i][0], "R6 R7 magnitude compare drdy", drdy_n, !VEC[i][0]);
      chk(st4() == 4'b0000, "R8 back to standby", st4(), 0);
      @(negedge clk);
      chk(drdy_n, "R7 drdy one cycle", drdy_n, 1);
    end

    thr = 24'd50;
    low_pulse(RST_LEN - 1);
    chk(det_mode, "R4 longest short pulse", det_mode, 1);
    send_cmd(16'h0033);
    chk(det_mode, "R9 command ignored in detect", det_mode, 1);
    @(negedge clk); sync_n = 0;
    repeat (RST_LEN) @(negedge clk);
    chk(st4() == 4'b1110, "R5 long pulse reset", st4(), 4'b1110);
    sync_n = 1;
    @(negedge clk);
    chk(st4() == 4'b1110, "R5 release no detect", st4(), 4'b1110);

    send_cmd(16'h0022);
    budget = 8'd4; limit = 8'd2;
    low_pulse(2);
    feed(24'd60);
    chk(drdy_n && det_mode, "R7 first hit no signal", st4(), 1);
    feed(24'd10);
    chk(drdy_n && det_mode, "R7 miss no signal", st4(), 1);
    feed(24'hFFFFC0);
    chk(!drdy_n && st4() == 0, "R7 limit reached", drdy_n, 0);

    budget = 8'd3; limit = 8'd2;
    low_pulse(2);
    feed(24'd5);
    feed(24'd70);
    chk(det_mode && drdy_n, "R8 budget not yet used", st4(), 1);
    feed(24'd5);
    chk(drdy_n && st4() == 0, "R8 silent return", drdy_n, 1);

    budget = 8'd1; limit = 8'd1;
    feed(24'd90);
    chk(drdy_n && st4() == 0, "R9 sample in standby ignored", drdy_n, 1);

    budget = 8'd3; limit = 8'd2;
    low_pulse(2);
    feed(24'd90);
    chk(drdy_n && det_mode, "R9 counters restart on entry", drdy_n, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule